// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block guards a processor bus against cycles that never finish. While the address strobe is asserted it counts system clocks. If no legitimate termination arrives before the count reaches a programmable limit, it drives a bus-error termination of its own. Interrupt acknowledge cycles are covered in the same way.

A cycle ends normally when any of the following is seen: either data-size acknowledge, an external bus error, or halt. During an interrupt acknowledge cycle, an autovector request also ends the cycle; outside such cycles it is not a termination. Once a termination is accepted, the cycle is finished for the monitor and it stays quiet until the strobe negates. A bus error produced by timeout is held until the strobe negates.

The monitor sits beside the bus controller. Its bus-error output is merged with the other bus-error sources in the system. A two-bit select picks the limit, and an enable input switches the function on or off.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset, busErrOut is low and the clock count is zero.
- R2: With monEnable high, limitSel encodes the limit as 0 = 128, 1 = 256, 2 = 512 and 3 = 1024 clocks. busErrOut rises right after the limit-th rising edge at which strobe is sampled high with no termination present, and not earlier.
- R3: A high on either bit of sizeAck, sampled with strobe high, terminates the cycle, and busErrOut stays low for the rest of that strobe.
- R4: haltIn sampled high with strobe high terminates the cycle, and no bus error follows.
- R5: avecIn terminates the cycle only while ackCycle is high. With ackCycle low, avecIn is ignored and the timeout still occurs at the full limit.
- R6: An interrupt acknowledge cycle (ackCycle high) that receives no termination times out at the same limit as any other cycle.
- R7: An external busErrIn sampled with strobe high terminates the count, and the monitor does not assert busErrOut during that strobe.
- R8: Once asserted, busErrOut stays high while strobe stays high. It goes low after the first rising edge at which strobe is sampled low.
- R9: While monEnable is low, busErrOut is never asserted.
- R10: A termination sampled at the same edge at which the count would reach the limit wins, and no bus error is raised.
- R11: The count restarts from zero on every new strobe, so a cycle that follows a near-limit cycle gets the full limit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| monEnable | input | 1 | Enables the monitor |
| limitSel | input | 2 | Timeout limit select (128 << limitSel clocks) |
| strobe | input | 1 | Address strobe, high while a bus cycle is open |
| sizeAck | input | 2 | Data-size acknowledges, either bit terminates |
| busErrIn | input | 1 | Bus error from another agent |
| haltIn | input | 1 | Halt termination |
| avecIn | input | 1 | Autovector request |
| ackCycle | input | 1 | High during an interrupt acknowledge cycle |
| busErrOut | output | 1 | Timeout bus error, held until strobe negates |

## Verification
The timeout and a normal termination can land on the same clock edge. The bench drives a data-size acknowledge so that it is sampled exactly at the limit-th edge of an open strobe. It then watches busErrOut for several clocks beyond the limit and requires it to stay low, because the termination takes precedence. A second run places the termination one edge earlier and then opens a fresh strobe. This shows that the counter restarts and that the fresh strobe times out after exactly the full limit.

// File: rtl/btm_pkg.sv
package btm_pkg;

  // control-to-datapath strobes
  typedef struct packed {
    logic clear;
    logic inc;
  } cntCtl_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DONE  = 2'd1,
    ST_FAULT = 2'd2
  } monState_t;

endpackage

// File: rtl/btm_datapath.sv
module btm_datapath
  import btm_pkg::*;
#(
  parameter int BASE_LIMIT = 128,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] limitSel,
  input  cntCtl_t          ctl,
  output logic             lastTick
);

  localparam int NUM_LIMITS = 1 << SEL_W;
  localparam int MAX_LIMIT  = BASE_LIMIT << (NUM_LIMITS - 1);
  localparam int CNT_W      = $clog2(MAX_LIMIT) + 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limitTable [NUM_LIMITS];
  logic [CNT_W-1:0] limitNow;

  // one limit per select code, each a doubling of the base
  for (genvar k = 0; k < NUM_LIMITS; k++) begin : g_limit
    assign limitTable[k] = CNT_W'(BASE_LIMIT << k);
  end

  assign limitNow = limitTable[limitSel];

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      count <= '0;
    end else if (ctl.inc) begin
      count <= count + 1'b1;
    end
  end

  // next increment would reach the limit (>= covers a select lowered mid-cycle)
  assign lastTick = (count >= limitNow - 1'b1);

  a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (count == '0));

  a_r2_inc_steps: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inc && !ctl.clear) |=> (count == $past(count) + 1'b1));

  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |=> (count == '0));

endmodule

// File: rtl/btm_ctrl.sv
module btm_ctrl
  import btm_pkg::*;
#(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             monEnable,
  input  logic             strobe,
  input  logic [ACK_W-1:0] sizeAck,
  input  logic             busErrIn,
  input  logic             haltIn,
  input  logic             avecIn,
  input  logic             ackCycle,
  input  logic             lastTick,
  output cntCtl_t          ctl,
  output logic             busErrOut
);

  monState_t state, stateNext;
  logic termSeen;

  // autovector ends only an interrupt acknowledge cycle
  assign termSeen = (|sizeAck) | busErrIn | haltIn | (avecIn & ackCycle);

  always_comb begin
    stateNext = state;
    ctl       = '{clear: 1'b0, inc: 1'b0};
    unique case (state)
      ST_RUN: begin
        if (!strobe || !monEnable) begin
          ctl.clear = 1'b1;
        end else if (termSeen) begin
          ctl.clear = 1'b1;
          stateNext = ST_DONE;
        end else if (lastTick) begin
          ctl.clear = 1'b1;
          stateNext = ST_FAULT;
        end else begin
          ctl.inc = 1'b1;
        end
      end
      ST_DONE, ST_FAULT: begin
        ctl.clear = 1'b1;
        if (!strobe) stateNext = ST_RUN;
      end
      default: begin
        ctl.clear = 1'b1;
        stateNext = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign busErrOut = (state == ST_FAULT);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busErrOut && strobe) |=> busErrOut);

  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    (busErrOut && !strobe) |=> !busErrOut);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!monEnable && !busErrOut) |=> !busErrOut);

  a_r7_ext_berr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busErrIn && !busErrOut) |=> !busErrOut);

  a_r5_avec_in_ack: assert property (@(posedge clk) disable iff (!rstN)
    (avecIn && ackCycle && !busErrOut) |=> !busErrOut);

  a_r10_term_wins: assert property (@(posedge clk) disable iff (!rstN)
    (termSeen && !busErrOut) |=> !busErrOut);

  a_r2_fault_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busErrOut) |-> $past(lastTick && strobe && monEnable));

endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor
  import btm_pkg::*;
#(
  parameter int BASE_LIMIT = 128,
  parameter int SEL_W      = 2,
  parameter int ACK_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             monEnable,
  input  logic [SEL_W-1:0] limitSel,
  input  logic             strobe,
  input  logic [ACK_W-1:0] sizeAck,
  input  logic             busErrIn,
  input  logic             haltIn,
  input  logic             avecIn,
  input  logic             ackCycle,
  output logic             busErrOut
);

  cntCtl_t ctl;
  logic    lastTick;

  btm_ctrl #(.ACK_W(ACK_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .monEnable (monEnable),
    .strobe    (strobe),
    .sizeAck   (sizeAck),
    .busErrIn  (busErrIn),
    .haltIn    (haltIn),
    .avecIn    (avecIn),
    .ackCycle  (ackCycle),
    .lastTick  (lastTick),
    .ctl       (ctl),
    .busErrOut (busErrOut)
  );

  btm_datapath #(.BASE_LIMIT(BASE_LIMIT), .SEL_W(SEL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .limitSel (limitSel),
    .ctl      (ctl),
    .lastTick (lastTick)
  );

endmodule

// File: tb/bus_timeout_monitor_test.sv
module bus_timeout_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int BASE = 128;

  // termination kinds
  localparam int K_NONE = 0, K_ACK0 = 1, K_ACK1 = 2, K_BERR = 3, K_HALT = 4, K_AVEC = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic monEnable = 1'b0;
  logic [1:0] limitSel = 2'd0;
  logic strobe = 1'b0;
  logic [1:0] sizeAck = 2'b00;
  logic busErrIn = 1'b0;
  logic haltIn = 1'b0;
  logic avecIn = 1'b0;
  logic ackCycle = 1'b0;
  logic busErrOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_timeout_monitor uut (
    .clk(clk), .rstN(rstN), .monEnable(monEnable), .limitSel(limitSel),
    .strobe(strobe), .sizeAck(sizeAck), .busErrIn(busErrIn), .haltIn(haltIn),
    .avecIn(avecIn), .ackCycle(ackCycle), .busErrOut(busErrOut)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic driveTerm(input int kind, input logic v);
    case (kind)
      K_ACK0: sizeAck[0] = v;
      K_ACK1: sizeAck[1] = v;
      K_BERR: busErrIn = v;
      K_HALT: haltIn = v;
      K_AVEC: avecIn = v;
      default: ;
    endcase
  endtask

  // opens a strobe, optionally terminates at edge termEdge, records first edge with busErrOut
  task automatic runCycle(input string req, input int sel, input int kind,
                          input int termEdge, input bit expectErr);
    int lim = BASE << sel;
    int firstRise = 0;
    limitSel = 2'(sel);
    @(negedge clk);
    strobe = 1'b1;
    for (int e = 1; e <= lim + 4; e++) begin
      if (e == termEdge) driveTerm(kind, 1'b1);
      @(posedge clk);
      @(negedge clk);
      driveTerm(kind, 1'b0);
      if (busErrOut && firstRise == 0) firstRise = e;
    end
    check({req, " first error edge"}, firstRise, expectErr ? lim : 0);
    check({req, " R8 level before strobe drop"}, int'(busErrOut), expectErr ? 1 : 0);
    strobe = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({req, " R8 released after strobe drop"}, int'(busErrOut), 0);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset output", int'(busErrOut), 0);
    rstN = 1'b1;
    monEnable = 1'b1;
    @(negedge clk);
    check("R1 idle output", int'(busErrOut), 0);
  endtask

  task automatic testLimits();
    for (int s = 0; s < 4; s++) runCycle("R2 limit select", s, K_NONE, 0, 1'b1);
  endtask

  task automatic testTerminations();
    runCycle("R3 sizeAck bit0", 0, K_ACK0, 20, 1'b0);
    runCycle("R3 sizeAck bit1", 0, K_ACK1, 5, 1'b0);
    runCycle("R4 halt", 0, K_HALT, 60, 1'b0);
    runCycle("R7 external bus error", 0, K_BERR, 100, 1'b0);
  endtask

  task automatic testAvec();
    ackCycle = 1'b0;
    runCycle("R5 avec outside ack cycle", 0, K_AVEC, 10, 1'b1);
    ackCycle = 1'b1;
    runCycle("R5 avec in ack cycle", 0, K_AVEC, 10, 1'b0);
    runCycle("R6 ack cycle timeout", 0, K_NONE, 0, 1'b1);
    ackCycle = 1'b0;
  endtask

  task automatic testDisabled();
    monEnable = 1'b0;
    runCycle("R9 disabled", 0, K_NONE, 0, 1'b0);
    monEnable = 1'b1;
  endtask

  task automatic testCollision();
    runCycle("R10 term at limit edge", 0, K_ACK0, BASE, 1'b0);
    runCycle("R11 near-limit term", 0, K_HALT, BASE - 1, 1'b0);
    runCycle("R11 restart full limit", 0, K_NONE, 0, 1'b1);
  endtask

  initial begin
    testReset();
    testLimits();
    testTerminations();
    testAvec();
    testDisabled();
    testCollision();
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule